// File: doc/BRIEF.md
# Status Transition-Filter Register Group

This block watches a 16-bit vector of live instrument conditions and turns selected changes on those conditions into sticky event flags. Every bit position has two programmable masks. One decides whether a 0-to-1 change on that condition counts as an event. The other decides whether a 1-to-0 change counts. A change that passes its mask sets the matching bit of an event register, and that bit stays set until software collects it.

A host uses a simple register port to read the live conditions, the two edge masks, the event flags and an enable mask. It can write the two edge masks and the enable mask. Reading the event register clears it in the same access. A separate clear-status input wipes the event flags and leaves the edge masks alone. The enable mask selects which event bits feed a single summary output. Bit positions that the parameter `UNUSED_MASK` marks as not implemented always read as zero and never raise an event.

Top module: `stat_xfilt_group`

## Requirements
- R1: A read of address 0 returns the live condition input as it stood in the read cycle, with every unimplemented bit forced to zero. Write data sent to address 0 changes nothing.
- R2: A 0-to-1 change on an implemented condition bit sets the matching event bit one clock later only when the matching bit of the rise mask (address 1) is 1. No event bit becomes newly set unless its condition bit changed.
- R3: A 1-to-0 change on an implemented condition bit sets the matching event bit one clock later only when the matching bit of the fall mask (address 2) is 1.
- R4: A position whose two mask bits are both 1 records both kinds of change. A position whose two mask bits are both 0 records neither.
- R5: While reset is low, the rise mask becomes all ones, the fall mask all zeros, the enable mask zero and the event register zero. A condition that is already high when reset is released produces no event.
- R6: The rise mask, fall mask and enable mask (addresses 1, 2 and 4) read back what was last written to them. Clear-status and register reads leave them unchanged.
- R7: Event bits are sticky. A read of address 3 returns them and clears them in the same cycle, and clear-status also clears them. An event detected in the same cycle as either kind of clear is kept.
- R8: `summary` is high exactly when some event bit is set whose enable-mask bit (address 4) is also 1.
- R9: Bits set in `UNUSED_MASK` (default bits 15 and 14) read as zero at addresses 0 and 3 and never set an event.
- R10: Read data appears on `reg_rdata` on the clock edge that samples `reg_rd`. Reads of addresses 5 to 7 return zero, and writes to those addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, equivalent to the power-on reset command |
| clr_stat | input | 1 | Clears the event register; leaves the masks unchanged |
| cond_in | input | 16 | Live condition vector |
| reg_addr | input | 3 | Register select: 0 condition, 1 rise mask, 2 fall mask, 3 event, 4 enable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| summary | output | 1 | OR of the event bits that are enabled |

## Verification
A condition change takes effect at the first clock edge after it is applied. Its event, and any change to `summary`, can therefore be seen one edge after the change. Register read data is registered, so it is valid after the edge that samples `reg_rd`. The bench drives every input on the falling edge. The driver queues the expected value when it issues a read, and the monitor compares it at the next falling edge, one edge after the read was sampled. Summary checks are made one full cycle after the triggering stimulus, so the event register has already been updated when they are sampled.

// File: rtl/stat_xfilt_group.sv
module stat_xfilt_group #(
  parameter int WIDTH = 16,
  parameter int AW = 3,
  parameter logic [WIDTH-1:0] UNUSED_MASK = 16'hC000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_stat,
  input  logic [WIDTH-1:0] cond_in,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  output logic             summary
);
  localparam logic [AW-1:0] A_COND   = AW'(0);
  localparam logic [AW-1:0] A_RISE   = AW'(1);
  localparam logic [AW-1:0] A_FALL   = AW'(2);
  localparam logic [AW-1:0] A_EVENT  = AW'(3);
  localparam logic [AW-1:0] A_ENABLE = AW'(4);

  logic [WIDTH-1:0] cond_live, prev_q, rise_q, fall_q, event_q, en_q, set_vec;
  logic evt_rd;

  assign cond_live = cond_in & ~UNUSED_MASK;
  assign set_vec   = (cond_live & ~prev_q & rise_q) | (~cond_live & prev_q & fall_q);
  assign evt_rd    = reg_rd && (reg_addr == A_EVENT);
  assign summary   = |(event_q & en_q);

  always_ff @(posedge clk) prev_q <= cond_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_q    <= '1;
      fall_q    <= '0;
      en_q      <= '0;
      event_q   <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_RISE:   rise_q <= reg_wdata;
          A_FALL:   fall_q <= reg_wdata;
          A_ENABLE: en_q   <= reg_wdata;
          default: ;
        endcase
      end
      if (evt_rd || clr_stat) event_q <= set_vec;
      else                    event_q <= event_q | set_vec;
      if (reg_rd) begin
        case (reg_addr)
          A_COND:   reg_rdata <= cond_live;
          A_RISE:   reg_rdata <= rise_q;
          A_FALL:   reg_rdata <= fall_q;
          A_EVENT:  reg_rdata <= event_q;
          A_ENABLE: reg_rdata <= en_q;
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

module stat_xfilt_group_chk #(
  parameter int WIDTH = 16,
  parameter int AW = 3,
  parameter logic [WIDTH-1:0] UNUSED_MASK = 16'hC000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_stat,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [AW-1:0]    reg_addr,
  input logic [WIDTH-1:0] cond_in,
  input logic [WIDTH-1:0] prev_q,
  input logic [WIDTH-1:0] rise_q,
  input logic [WIDTH-1:0] fall_q,
  input logic [WIDTH-1:0] event_q,
  input logic [WIDTH-1:0] en_q,
  input logic             summary
);
  a_r5_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (rise_q == '1 && fall_q == '0 && en_q == '0 && event_q == '0));

  a_r9_unused_never_set: assert property (@(posedge clk) disable iff (!rst_n)
    (event_q & UNUSED_MASK) == '0);

  a_r2_event_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (event_q & ~$past(event_q) & ~($past(cond_in) ^ $past(prev_q))) == '0);

  a_r7_clear_keeps_only_new: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat || (reg_rd && reg_addr == AW'(3)))
      |=> (event_q & ~($past(cond_in) ^ $past(prev_q))) == '0);

  a_r6_masks_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(rise_q) && $stable(fall_q) && $stable(en_q)));

  a_r8_no_summary_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !summary);
endmodule

bind stat_xfilt_group stat_xfilt_group_chk #(
  .WIDTH(WIDTH), .AW(AW), .UNUSED_MASK(UNUSED_MASK)
) u_chk (.*);

// File: tb/stat_xfilt_group_tb.sv
module stat_xfilt_group_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_stat = 1'b0;
  logic [15:0] cond_in = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        summary;

  int checks = 0;
  int failures = 0;
  logic rd_flag = 1'b0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  bit finished = 0;

  stat_xfilt_group u_dut (.*);

  always #5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  always @(posedge clk) rd_flag <= reg_rd;

  always @(negedge clk) begin
    if (rd_flag) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected read actual=%h expected=none", reg_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, reg_rdata, e);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    // R5 reset state
    do_read(3'd1, 16'hFFFF, "R5 rise mask reset");
    do_read(3'd2, 16'h0000, "R5 fall mask reset");
    do_read(3'd4, 16'h0000, "R5 enable reset");
    do_read(3'd3, 16'h0000, "R5 event reset");
    tick(1);
    check("R5 summary reset", {15'd0, summary}, 16'h0000);

    // R1, R2, R9 rising edges with default masks
    @(negedge clk) cond_in = 16'hFFFF;
    tick(2);
    do_read(3'd0, 16'h3FFF, "R1 R9 condition read");
    do_read(3'd3, 16'h3FFF, "R2 R9 rising events");
    do_read(3'd3, 16'h0000, "R7 read clears");
    // R3 falls blocked by default fall mask
    @(negedge clk) cond_in = 16'h0000;
    tick(2);
    do_read(3'd3, 16'h0000, "R3 fall blocked");

    // R6 mask write/readback
    do_write(3'd1, 16'h0F0F);
    do_write(3'd2, 16'h00FF);
    do_read(3'd1, 16'h0F0F, "R6 rise readback");
    do_read(3'd2, 16'h00FF, "R6 fall readback");

    // R2/R3/R4 per-bit filtering
    @(negedge clk) cond_in = 16'h00FF;
    tick(2);
    do_read(3'd3, 16'h000F, "R2 rise filtered");
    @(negedge clk) cond_in = 16'h0000;
    tick(2);
    do_read(3'd3, 16'h00FF, "R3 R4 fall filtered");
    @(negedge clk) cond_in = 16'h3000;
    @(negedge clk) cond_in = 16'h0000;
    tick(2);
    do_read(3'd3, 16'h0000, "R4 both masks zero");

    // R8 summary and R7 stickiness / clear-status
    do_write(3'd4, 16'h0001);
    @(negedge clk) cond_in = 16'h0001;
    tick(1);
    check("R8 summary set", {15'd0, summary}, 16'h0001);
    tick(5);
    check("R7 sticky summary", {15'd0, summary}, 16'h0001);
    @(negedge clk) clr_stat = 1'b1;
    @(negedge clk) clr_stat = 1'b0;
    check("R7 clear-status", {15'd0, summary}, 16'h0000);
    do_read(3'd1, 16'h0F0F, "R6 rise after clear");
    do_read(3'd2, 16'h00FF, "R6 fall after clear");
    do_read(3'd4, 16'h0001, "R6 enable after clear");
    // R7 event coinciding with clear is kept
    @(negedge clk) begin cond_in = 16'h0000; clr_stat = 1'b1; end
    @(negedge clk) clr_stat = 1'b0;
    do_read(3'd3, 16'h0001, "R7 event kept with clear");
    // R7 event coinciding with read-clear is kept
    @(negedge clk) begin cond_in = 16'h0001; reg_rd = 1'b1; reg_addr = 3'd3;
      exp_q.push_back(16'h0000); tag_q.push_back("R7 read during edge"); end
    @(negedge clk) reg_rd = 1'b0;
    do_read(3'd3, 16'h0001, "R7 event kept with read-clear");
    // R8 disabled bit does not raise summary
    @(negedge clk) cond_in = 16'h0003;
    tick(2);
    check("R8 disabled event", {15'd0, summary}, 16'h0000);
    do_read(3'd3, 16'h0002, "R8 event present");

    // R10 unused addresses, R1 write to condition ignored
    do_write(3'd7, 16'hFFFF);
    do_write(3'd0, 16'hFFFF);
    do_read(3'd7, 16'h0000, "R10 unused address");
    do_read(3'd0, 16'h0003, "R1 write ignored");
    do_read(3'd1, 16'h0F0F, "R10 write to unused address ignored");

    // R5 reset mid-run, condition held high
    @(negedge clk) rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    do_read(3'd1, 16'hFFFF, "R5 rise after reset");
    do_read(3'd2, 16'h0000, "R5 fall after reset");
    do_read(3'd4, 16'h0000, "R5 enable after reset");
    do_read(3'd3, 16'h0000, "R5 no event from held condition");

    tick(3);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R10 pending reads actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule